// File: doc/BRIEF.md
# Set-Associative Software-Loaded Translation Buffer Lookup

This block translates a page of the effective address through a small translation buffer. Software fills the buffer through a write port, and there is no hardware page-table walk. The storage has two halves. One half serves instruction fetches and the other serves loads and stores. Each half is organised as a number of ways times a number of sets. The page is 4 KB, so the set index comes from the address bits directly above the page offset.

A lookup is combinational. The caller gives:
- the effective address,
- the access kind,
- the compare word that the matching entry's first word must carry,
- the protection key for the current privilege,
- the no-execute flag of the segment.

The block returns:
- whether the access was granted (hit),
- whether a matching entry refused it (fault),
- the stored second word of the selected entry,
- the permissions that apply to the page.

When a qualified lookup selects an entry, the referenced flag is written back at the next clock edge. The changed flag is also written back, but only for a granted store. Until the changed flag is set, write permission is withheld from the returned permissions. The first write to a page therefore has to go through as a store.

Top module: `tlb6_lookup`

## Requirements
- R1: The entry probed in way w is set + w*SETS, where set is EA[16:12]. A fetch (acc_i = 2) adds WAYS*SETS, so fetches see only the instruction half and loads (0) and stores (1) see only the data half. The write port places entries with the same formula, using wr_fetch_i, wr_way_i and wr_set_i.
- R2: An entry matches only when all four conditions hold: bit 31 of its first word is 1, bit 6 of its first word is 0, the first word equals cmp_i under mask 32'h7FFFFFBF, and its stored page number equals EA[31:12].
- R3: Permissions come from PP (bits 1:0 of the second word) and key_i. With key 0, PP values 0, 1 and 2 give read and write, and PP 3 gives read only. With key 1, PP 0 gives nothing, PP 1 and PP 3 give read only, and PP 2 gives read and write. Execute equals read unless nx_i is 1. perm_o is {read, write, execute}.
- R4: A load needs read, a store needs write and a fetch needs execute. hit_o is 1 when a matching entry allows the access.
- R5: Ways are probed from way 0 upward. The first matching entry that allows the access ends the search. A matching entry that refuses the access becomes the recorded entry and the search goes on. fault_o is 1 when at least one entry matched and none allowed the access.
- R6: Once an entry is recorded, a later matching entry whose second word differs from it under mask 32'hFFFFF07B is ignored.
- R7: When lookup_valid_i is 1 and the result is a hit or a fault, bit 8 (referenced) of the selected entry's second word is set at the next clock edge.
- R8: Bit 7 (changed) of the selected entry is set only after a granted store with lookup_valid_i at 1.
- R9: If the selected entry's bit 7 is clear and the access is not a granted store, the write bit of perm_o is 0.
- R10: word_o is the selected entry's second word as stored before the write-back. On a miss, word_o and perm_o are 0 and neither hit_o nor fault_o is asserted.
- R11: With wr_en_i at 1, the page number and both words are stored at the next edge. This write wins over a flag write-back to the same entry in the same cycle.
- R12: After reset every entry is invalid and every lookup misses.
- R13: With lookup_valid_i at 0, a lookup changes no stored flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lookup_valid_i | input | 1 | Lookup is real; enables flag write-back |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | 0 load, 1 store, 2 fetch |
| cmp_i | input | 32 | Expected first-word compare value |
| key_i | input | 1 | Protection key |
| nx_i | input | 1 | No-execute flag of the segment |
| wr_en_i | input | 1 | Load an entry |
| wr_fetch_i | input | 1 | Target the instruction half |
| wr_way_i | input | 1 | Target way |
| wr_set_i | input | 5 | Target set |
| wr_epn_i | input | 20 | Page number to store |
| wr_w0_i | input | 32 | First word to store |
| wr_w1_i | input | 32 | Second word to store |
| hit_o | output | 1 | Access granted |
| fault_o | output | 1 | Matched, but protection refused |
| word_o | output | 32 | Second word of the selected entry |
| perm_o | output | 3 | {read, write, execute} |

## Verification
The flag assertions assume that acc_i never carries the code 3. They also assume that a write to the selected entry does not coincide with the write-back they check, which is why they are qualified by wr_en_i at 0. The bench keeps to these conditions except in the single scenario that checks write priority. In that scenario the effect is observed through a later lookup instead. Every access code the bench drives is 0, 1 or 2. Entry contents are chosen so that each way holds a page number distinct from its neighbours unless a scenario asks for a multi-way match.

// File: rtl/tlb6_pkg.sv
package tlb6_pkg;
    localparam int EA_W    = 32;
    localparam int PG_BITS = 12;
    localparam int EPN_W   = EA_W - PG_BITS;

    localparam logic [31:0] CMP_MASK = 32'h7FFF_FFBF;
    localparam logic [31:0] CHK_MASK = 32'hFFFF_F07B;
    localparam int VALID_POS = 31;
    localparam int HSEL_POS  = 6;
    localparam int REF_POS   = 8;
    localparam int CHG_POS   = 7;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic [EPN_W-1:0] epn;
        logic [31:0]      w0;
        logic [31:0]      w1;
    } ent_t;
endpackage

// File: rtl/tlb6_perm_decode.sv
module tlb6_perm_decode (
    input  logic [1:0] pp_i,
    input  logic       key_i,
    input  logic       nx_i,
    output logic [2:0] perm_o
);
    logic rd, wr;

    always_comb begin
        if (key_i) begin
            rd = (pp_i != 2'd0);
            wr = (pp_i == 2'd2);
        end else begin
            rd = 1'b1;
            wr = (pp_i != 2'd3);
        end
        perm_o = {rd, wr, rd & ~nx_i};
    end
endmodule

// File: rtl/tlb6_way_probe.sv
module tlb6_way_probe
    import tlb6_pkg::*;
(
    input  ent_t             ent_i,
    input  logic [EPN_W-1:0] ea_page_i,
    input  logic [31:0]      cmp_i,
    input  logic             key_i,
    input  logic             nx_i,
    input  acc_e             acc_i,
    output logic             match_o,
    output logic [2:0]       perm_o,
    output logic             grant_o
);
    tlb6_perm_decode u_dec (
        .pp_i  (ent_i.w1[1:0]),
        .key_i (key_i),
        .nx_i  (nx_i),
        .perm_o(perm_o)
    );

    always_comb begin
        match_o = ent_i.w0[VALID_POS] && !ent_i.w0[HSEL_POS]
                  && ((ent_i.w0 & CMP_MASK) == (cmp_i & CMP_MASK))
                  && (ent_i.epn == ea_page_i);
        unique case (acc_i)
            ACC_LOAD:  grant_o = perm_o[2];
            ACC_STORE: grant_o = perm_o[1];
            ACC_FETCH: grant_o = perm_o[0];
            default:   grant_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb6_lookup.sv
module tlb6_lookup
    import tlb6_pkg::*;
#(
    parameter int WAYS = 2,
    parameter int SETS = 32
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        lookup_valid_i,
    input  logic [31:0] ea_i,
    input  logic [1:0]  acc_i,
    input  logic [31:0] cmp_i,
    input  logic        key_i,
    input  logic        nx_i,
    input  logic        wr_en_i,
    input  logic        wr_fetch_i,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] wr_way_i,
    input  logic [((SETS > 1) ? $clog2(SETS) : 1)-1:0] wr_set_i,
    input  logic [19:0] wr_epn_i,
    input  logic [31:0] wr_w0_i,
    input  logic [31:0] wr_w1_i,
    output logic        hit_o,
    output logic        fault_o,
    output logic [31:0] word_o,
    output logic [2:0]  perm_o
);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int HALF  = WAYS * SETS;
    localparam int NUM   = 2 * HALF;
    localparam int IDX_W = $clog2(NUM);

    typedef struct packed {
        ent_t [NUM-1:0] tbl;
    } state_t;

    state_t st_d, st_q;

    acc_e             acc;
    logic [SET_W-1:0] ea_set;
    logic [IDX_W-1:0] way_idx [WAYS];
    logic [WAYS-1:0]  way_match, way_grant;
    logic [2:0]       way_perm [WAYS];
    logic [31:0]      way_w1   [WAYS];
    logic [IDX_W-1:0] wr_idx;

    logic             rec_have, rec_grant;
    logic [31:0]      rec_word;
    logic [2:0]       rec_perm;
    logic [IDX_W-1:0] rec_idx;

    assign acc    = acc_e'(acc_i);
    assign ea_set = ea_i[PG_BITS +: SET_W];
    assign wr_idx = IDX_W'(wr_set_i) + IDX_W'(wr_way_i) * IDX_W'(SETS)
                    + (wr_fetch_i ? IDX_W'(HALF) : IDX_W'(0));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_idx[w] = IDX_W'(ea_set) + IDX_W'(w * SETS)
                            + ((acc == ACC_FETCH) ? IDX_W'(HALF) : IDX_W'(0));
        assign way_w1[w]  = st_q.tbl[way_idx[w]].w1;

        tlb6_way_probe u_probe (
            .ent_i    (st_q.tbl[way_idx[w]]),
            .ea_page_i(ea_i[EA_W-1:PG_BITS]),
            .cmp_i    (cmp_i),
            .key_i    (key_i),
            .nx_i     (nx_i),
            .acc_i    (acc),
            .match_o  (way_match[w]),
            .perm_o   (way_perm[w]),
            .grant_o  (way_grant[w])
        );
    end

    always_comb begin
        st_d      = st_q;
        rec_have  = 1'b0;
        rec_grant = 1'b0;
        rec_word  = '0;
        rec_perm  = '0;
        rec_idx   = '0;

        // ordered probe: a granted match stops, a refused one is kept
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w] && !rec_grant) begin
                if (!rec_have || ((rec_word & CHK_MASK) == (way_w1[w] & CHK_MASK))) begin
                    rec_have  = 1'b1;
                    rec_word  = way_w1[w];
                    rec_perm  = way_perm[w];
                    rec_idx   = way_idx[w];
                    rec_grant = way_grant[w];
                end
            end
        end

        hit_o   = rec_grant;
        fault_o = rec_have && !rec_grant;
        word_o  = rec_word;
        perm_o  = rec_perm;
        if (rec_have && !rec_word[CHG_POS] && !(acc == ACC_STORE && rec_grant)) begin
            perm_o[1] = 1'b0;
        end

        if (lookup_valid_i && rec_have) begin
            st_d.tbl[rec_idx].w1[REF_POS] = 1'b1;
            if (acc == ACC_STORE && rec_grant) begin
                st_d.tbl[rec_idx].w1[CHG_POS] = 1'b1;
            end
        end

        // software load wins over flag write-back
        if (wr_en_i) begin
            st_d.tbl[wr_idx] = '{epn: wr_epn_i, w0: wr_w0_i, w1: wr_w1_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r5_hit_fault_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hit_o && fault_o));

    a_r4_grant_has_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> ((acc == ACC_LOAD  && perm_o[2]) ||
                   (acc == ACC_STORE && perm_o[1]) ||
                   (acc == ACC_FETCH && perm_o[0])));

    a_r10_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hit_o && !fault_o) |-> (word_o == 32'h0 && perm_o == 3'b000));

    a_r7_ref_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lookup_valid_i && (hit_o || fault_o) && !wr_en_i)
        |=> st_q.tbl[$past(rec_idx)].w1[REF_POS]);

    a_r8_chg_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lookup_valid_i && hit_o && acc == ACC_STORE && !wr_en_i)
        |=> st_q.tbl[$past(rec_idx)].w1[CHG_POS]);

    a_r13_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lookup_valid_i && !wr_en_i) |=> $stable(st_q));

    a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (st_q.tbl[$past(wr_idx)].w1 == $past(wr_w1_i)
                     && st_q.tbl[$past(wr_idx)].epn == $past(wr_epn_i)));
endmodule

// File: tb/tlb6_lookup_tb_top.sv
module tlb6_lookup_tb_top;
    localparam int WAYS = 2;
    localparam int SETS = 32;
    localparam int HALF = WAYS * SETS;
    localparam int NUM  = 2 * HALF;
    localparam logic [31:0] M_CMP = 32'h7FFF_FFBF;
    localparam logic [31:0] M_CHK = 32'hFFFF_F07B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lv = 1'b0;
    logic [31:0] ea = '0;
    logic [1:0]  acc = '0;
    logic [31:0] cmp = '0;
    logic        key = 1'b0, nx = 1'b0;
    logic        we = 1'b0, wf = 1'b0;
    logic [0:0]  wway = '0;
    logic [4:0]  wset = '0;
    logic [19:0] wepn = '0;
    logic [31:0] ww0 = '0, ww1 = '0;
    logic        hit, fault;
    logic [31:0] word;
    logic [2:0]  perm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [19:0] m_epn [NUM];
    logic [31:0] m_w0  [NUM];
    logic [31:0] m_w1  [NUM];

    always #4 clk = ~clk;

    tlb6_lookup #(.WAYS(WAYS), .SETS(SETS)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lv), .ea_i(ea), .acc_i(acc),
        .cmp_i(cmp), .key_i(key), .nx_i(nx), .wr_en_i(we), .wr_fetch_i(wf),
        .wr_way_i(wway), .wr_set_i(wset), .wr_epn_i(wepn), .wr_w0_i(ww0),
        .wr_w1_i(ww1), .hit_o(hit), .fault_o(fault), .word_o(word), .perm_o(perm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int midx(input bit fetch, input int way, input int set);
        return set + way * SETS + (fetch ? HALF : 0);
    endfunction

    function automatic logic [2:0] mperm(input logic [1:0] pp, input logic k, input logic n);
        logic [1:0] rw;
        case ({k, pp})
            3'b011:         rw = 2'b10;
            3'b100:         rw = 2'b00;
            3'b101, 3'b111: rw = 2'b10;
            default:        rw = 2'b11;
        endcase
        return {rw, rw[1] & ~n};
    endfunction

    task automatic model_search(output logic e_hit, output logic e_fault,
                                output logic [31:0] e_word, output logic [2:0] e_perm,
                                output int e_sel);
        logic have = 1'b0, grant = 1'b0, ok;
        logic [31:0] wd = '0;
        logic [2:0] p = '0;
        e_sel = 0;
        for (int w = 0; w < WAYS; w++) begin
            int i = midx(acc == 2'd2, w, int'(ea[16:12]));
            logic mt = m_w0[i][31] && !m_w0[i][6] && ((m_w0[i] & M_CMP) == (cmp & M_CMP))
                       && (m_epn[i] == ea[31:12]);
            if (mt && !grant && (!have || ((wd & M_CHK) == (m_w1[i] & M_CHK)))) begin
                have = 1'b1;
                wd = m_w1[i];
                p = mperm(m_w1[i][1:0], key, nx);
                e_sel = i;
                ok = (acc == 2'd0) ? p[2] : (acc == 2'd1) ? p[1] : p[0];
                if (ok) grant = 1'b1;
            end
        end
        if (have && !wd[7] && !(acc == 2'd1 && grant)) p[1] = 1'b0;
        e_hit = grant;
        e_fault = have && !grant;
        e_word = wd;
        e_perm = p;
    endtask

    // one clock cycle: optional lookup check, optional write
    task automatic cycle(input logic l_v, input logic [31:0] l_ea, input logic [1:0] l_acc,
                         input logic [31:0] l_cmp, input logic l_key, input logic l_nx,
                         input logic w_e, input bit w_f, input int w_way, input int w_set,
                         input logic [19:0] w_epn, input logic [31:0] w_0, input logic [31:0] w_1,
                         input string tag);
        logic eh, ef;
        logic [31:0] ew;
        logic [2:0] ep;
        int sel;
        @(negedge clk);
        lv = l_v; ea = l_ea; acc = l_acc; cmp = l_cmp; key = l_key; nx = l_nx;
        we = w_e; wf = w_f; wway = 1'(w_way); wset = 5'(w_set);
        wepn = w_epn; ww0 = w_0; ww1 = w_1;
        #1;
        model_search(eh, ef, ew, ep, sel);
        chk({tag, " hit"},   {31'b0, hit},   {31'b0, eh});
        chk({tag, " fault"}, {31'b0, fault}, {31'b0, ef});
        chk({tag, " word"},  word, ew);
        chk({tag, " perm"},  {29'b0, perm}, {29'b0, ep});
        @(posedge clk);
        #1;
        if (l_v && (eh || ef)) begin
            m_w1[sel][8] = 1'b1;
            if (eh && l_acc == 2'd1) m_w1[sel][7] = 1'b1;
        end
        if (w_e) begin
            int i = midx(w_f, w_way, w_set);
            m_epn[i] = w_epn; m_w0[i] = w_0; m_w1[i] = w_1;
        end
        lv = 1'b0; we = 1'b0;
    endtask

    task automatic put(input bit f, input int w, input int s, input logic [19:0] e,
                       input logic [31:0] a, input logic [31:0] b);
        cycle(1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b1, f, w, s, e, a, b, "R11 write");
    endtask

    task automatic look(input logic v, input logic [31:0] a, input logic [1:0] c,
                        input logic [31:0] m, input logic k, input logic n, input string tag);
        cycle(v, a, c, m, k, n, 1'b0, 1'b0, 0, 0, 20'h0, 32'h0, 32'h0, tag);
    endtask

    initial begin
        logic [31:0] cw;
        cw = 32'h8000_0000 | (32'h0123_4527 & M_CMP);
        for (int i = 0; i < NUM; i++) begin m_epn[i] = '0; m_w0[i] = '0; m_w1[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R12: empty after reset
        look(1'b1, 32'h1234_5000, 2'd0, 32'h0, 1'b0, 1'b0, "R12 load");
        look(1'b1, 32'h0ABC_5000, 2'd2, cw,    1'b0, 1'b0, "R12 fetch");

        // R3 R4 R8 R9 R7: protection sweep on set 5 way 0
        for (int pp = 0; pp < 4; pp++)
            for (int k = 0; k < 2; k++)
                for (int n = 0; n < 2; n++)
                    for (int a = 0; a < 3; a++)
                        for (int c = 0; c < 2; c++) begin
                            put(a == 2, 0, 5, 20'h0ABC5, cw,
                                32'h5555_5018 | 32'(pp) | (c != 0 ? 32'h80 : 32'h0));
                            look(1'b1, 32'h0ABC_5000, 2'(a), cw, 1'(k), 1'(n), "R3 R4 R9");
                            look(1'b0, 32'h0ABC_5000, 2'(a), cw, 1'(k), 1'(n), "R7 R8");
                        end

        // R1: index and halves
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++)
                put(0, w, s, 20'h10000 | 20'(w << 8) | 20'(s), cw, 32'h0000_1002 | 32'(s << 16) | 32'(w << 24));
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s += 3) begin
                logic [31:0] e = {20'h10000 | 20'(w << 8) | 20'(s), 12'h0};
                look(1'b0, e, 2'd2, cw, 1'b0, 1'b0, "R1 fetch sees no data");
                look(1'b0, e, 2'd0, cw, 1'b0, 1'b0, "R1 data");
            end
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++)
                put(1, w, s, 20'h10000 | 20'(w << 8) | 20'(s), cw, 32'h0000_2002 | 32'(s << 16) | 32'(w << 24));
        for (int w = 0; w < WAYS; w++)
            for (int s = 0; s < SETS; s++) begin
                logic [31:0] e = {20'h10000 | 20'(w << 8) | 20'(s), 12'h0};
                look(1'b0, e, 2'd2, cw, 1'b0, 1'b0, "R1 fetch half");
                look(1'b0, e, 2'd1, cw, 1'b0, 1'b0, "R1 store half");
            end

        // R2: match conditions on set 9
        put(0, 1, 9, 20'h0, 32'h0, 32'h0);
        put(0, 0, 9, 20'h22229, cw, 32'h7700_0082);
        look(1'b0, 32'h2222_9000, 2'd0, cw, 1'b0, 1'b0, "R2 match");
        look(1'b0, 32'h2222_9000, 2'd0, cw ^ 32'h0000_0100, 1'b0, 1'b0, "R2 compare miss");
        look(1'b0, 32'h2222_9000, 2'd0, cw ^ 32'h8000_0040, 1'b0, 1'b0, "R2 masked bits ignored");
        look(1'b0, 32'h2223_9000, 2'd0, cw, 1'b0, 1'b0, "R2 page miss");
        put(0, 0, 9, 20'h22229, cw | 32'h40, 32'h7700_0082);
        look(1'b0, 32'h2222_9000, 2'd0, cw | 32'h40, 1'b0, 1'b0, "R2 hash select");
        put(0, 0, 9, 20'h22229, cw & 32'h7FFF_FFFF, 32'h7700_0082);
        look(1'b0, 32'h2222_9000, 2'd0, cw, 1'b0, 1'b0, "R2 invalid");

        // R5 R6: ordering on set 12
        put(0, 0, 12, 20'h3330C, cw, 32'h4400_0082);
        put(0, 1, 12, 20'h3330C, cw, 32'h4400_0086);
        look(1'b1, 32'h3330_C000, 2'd1, cw, 1'b0, 1'b0, "R5 first grant");
        look(1'b0, 32'h3330_C000, 2'd1, cw, 1'b0, 1'b0, "R5 way0 flagged");
        put(0, 0, 12, 20'h3330C, cw, 32'h4400_0003);
        put(0, 1, 12, 20'h3330C, cw, 32'h4400_0007);
        look(1'b1, 32'h3330_C000, 2'd1, cw, 1'b0, 1'b0, "R5 both refuse");
        look(1'b0, 32'h3330_C000, 2'd1, cw, 1'b0, 1'b0, "R5 last refusal flagged");
        put(0, 1, 12, 20'h3330C, cw, 32'h9900_0082);
        look(1'b1, 32'h3330_C000, 2'd1, cw, 1'b0, 1'b0, "R6 inconsistent ignored");
        look(1'b0, 32'h3330_C000, 2'd0, cw, 1'b0, 1'b0, "R6 readback");
        put(0, 0, 12, 20'h3340C, cw, 32'h4400_0003);
        look(1'b1, 32'h3330_C000, 2'd1, cw, 1'b0, 1'b0, "R5 second way alone");

        // R13: no flag change without lookup_valid_i
        put(0, 0, 20, 20'h55554, cw, 32'h1200_0002);
        put(0, 1, 20, 20'h0, 32'h0, 32'h0);
        look(1'b0, 32'h5555_4000, 2'd1, cw, 1'b0, 1'b0, "R13 probe");
        look(1'b0, 32'h5555_4000, 2'd1, cw, 1'b0, 1'b0, "R13 unchanged");

        // R11: write wins over write-back to the same entry
        cycle(1'b1, 32'h5555_4000, 2'd1, cw, 1'b0, 1'b0, 1'b1, 0, 0, 20, 20'h55554, cw,
              32'h3400_0001, "R11 collide");
        look(1'b0, 32'h5555_4000, 2'd0, cw, 1'b0, 1'b0, "R11 write kept");
        cycle(1'b1, 32'h5555_4000, 2'd0, cw, 1'b0, 1'b0, 1'b1, 0, 1, 3, 20'h66663, cw,
              32'h3500_0002, "R11 parallel");
        look(1'b0, 32'h5555_4000, 2'd0, cw, 1'b0, 1'b0, "R11 flag elsewhere");
        look(1'b0, 32'h6666_3000, 2'd0, cw, 1'b0, 1'b0, "R11 other entry");
        look(1'b0, 32'h7777_7000, 2'd0, cw, 1'b0, 1'b0, "R10 miss zeros");

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule